// File: doc/BRIEF.md
# Asynchronous CPU Bus to Wishbone Bridge

This block connects an external processor that uses a classic asynchronous bus to an on-chip Wishbone bus. The processor has a chip select, separate read and write strobes, byte enables and a shared bidirectional data bus. All of its control lines are active low. On the processor side the bridge is a slave. On the Wishbone side it is a master. The bridge samples the processor strobes in the Wishbone clock domain. Each strobe becomes one Wishbone transfer. The bridge holds the processor in wait until the Wishbone slave ends that transfer.

While the chip select stays low, successive strobes belong to one Wishbone cycle: CYC stays high across all of them, and STB pulses once per transfer. A read followed by a write to the same location therefore forms a read-modify-write cycle. Retry and error responses affect only the transfer in progress. A retried transfer is issued again, up to a parameterised limit. When the retry limit is reached, or when the slave reports an error, the bridge releases wait and returns all-ones read data.

Top module: `async_wb_bridge`

## Requirements
- R1: After reset, CYC and STB are low and the wait output is high (not waiting).
- R2: A falling write strobe while chip select is low produces one Wishbone write. WE is high, the address and data are those the processor presented, and SEL bit i is the inverse of byte-enable bit i (byte i is data bits 8i+7..8i).
- R3: A falling read strobe while chip select is low produces one Wishbone read. The data the slave returns with ACK appears on the processor data bus once wait is released.
- R4: Several strobes under one continuous low chip select produce exactly one STB pulse each, and CYC does not fall between them.
- R5: Within five clock cycles after chip select goes high, with no transfer pending, CYC is low.
- R6: On RTY the bridge drops STB for one cycle and then issues the same transfer again. If the slave then acknowledges, the transfer completes normally.
- R7: If RTY arrives on the transfer after RETRY_MAX reissues (RETRY_MAX+1 attempts in all), the bridge gives up, releases wait and returns all-ones read data.
- R8: ERR ends the transfer after a single attempt, releases wait and returns all-ones read data.
- R9: The bridge drives the data bus only while chip select and read are both low. During a write the processor's data reaches the slave unchanged.
- R10: Wait is low from the moment a strobe falls under a low chip select until the Wishbone transfer has ended, and stays low while STB is high.
- R11: A strobe while chip select is high starts no Wishbone transfer and does not assert wait.
- R12: A read followed by a write under one chip select forms a single Wishbone cycle, and the written value lands at the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Wishbone clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_addr_i | input | AW | Processor address |
| cpu_data_io | inout | DW | Processor bidirectional data bus |
| cpu_cs_ni | input | 1 | Processor chip select, active low |
| cpu_rd_ni | input | 1 | Processor read strobe, active low |
| cpu_wr_ni | input | 1 | Processor write strobe, active low |
| cpu_be_ni | input | DW/8 | Processor byte enables, active low |
| cpu_wait_no | output | 1 | Wait to processor, active low |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | AW | Wishbone address |
| wb_sel_o | output | DW/8 | Wishbone byte selects |
| wb_dat_o | output | DW | Wishbone write data |
| wb_dat_i | input | DW | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| wb_rty_i | input | 1 | Wishbone retry |
| wb_err_i | input | 1 | Wishbone error |

## Verification
The properties are checked on every cycle: STB is high only inside CYC, wait is held while STB is high, address and direction stay stable during a transfer, and STB falls right after ACK or ERR. The bench scenarios are what show the end-to-end effects: the read data that comes back, byte-merged writes, the attempt count when retries run out, strobes ignored while chip select is high, and one CYC spanning a read-modify-write. No cycle-level property covers those.

// File: rtl/abr_pkg.sv
package abr_pkg;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_BUSY = 2'd1,
    XF_GAP  = 2'd2,
    XF_DONE = 2'd3
  } xfer_state_e;

endpackage

// File: rtl/abr_sync.sv
// Two-flop synchroniser for a vector of asynchronous inputs.
module abr_sync #(
  parameter int         W      = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/abr_strobe_edge.sv
// Detects falling edges of the synchronised strobes under a low chip select.
module abr_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_ni,
  input  logic rd_s_ni,
  input  logic wr_s_ni,
  output logic start_o,
  output logic start_we_o,
  output logic strobes_idle_o,
  output logic cs_idle_o
);

  logic rd_prev_q;
  logic wr_prev_q;
  logic rd_fall;
  logic wr_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_prev_q <= 1'b1;
      wr_prev_q <= 1'b1;
    end else begin
      rd_prev_q <= rd_s_ni;
      wr_prev_q <= wr_s_ni;
    end
  end

  assign rd_fall        = rd_prev_q & ~rd_s_ni & ~cs_s_ni;
  assign wr_fall        = wr_prev_q & ~wr_s_ni & ~cs_s_ni;
  assign start_o        = rd_fall | wr_fall;
  assign start_we_o     = wr_fall;
  assign strobes_idle_o = rd_s_ni & wr_s_ni;
  assign cs_idle_o      = cs_s_ni;

endmodule

// File: rtl/abr_xfer_fsm.sv
// Wishbone master sequencer: one transfer per start, retry handling, CYC framing.
module abr_xfer_fsm
  import abr_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 16,
  parameter int RETRY_MAX = 3,
  localparam int NB       = DW / 8,
  localparam int RCW      = $clog2(RETRY_MAX + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          start_we_i,
  input  logic          strobes_idle_i,
  input  logic          cs_idle_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NB-1:0] sel_i,
  input  logic          ack_i,
  input  logic          rty_i,
  input  logic          err_i,
  input  logic [DW-1:0] dat_i,
  output logic          cyc_o,
  output logic          stb_o,
  output logic          we_o,
  output logic [AW-1:0] adr_o,
  output logic [NB-1:0] sel_o,
  output logic [DW-1:0] dat_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);

  localparam logic [RCW-1:0] RTY_LIMIT = RCW'(RETRY_MAX);

  xfer_state_e    state_q, state_d;
  logic           cyc_q, cyc_d;
  logic           we_q;
  logic [AW-1:0]  adr_q;
  logic [NB-1:0]  sel_q;
  logic [DW-1:0]  wdat_q;
  logic [DW-1:0]  rdat_q, rdat_d;
  logic [RCW-1:0] rty_q, rty_d;
  logic           cap_en;
  logic           rdat_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cyc_d   = cyc_q;
    rdat_d  = rdat_q;
    rty_d   = rty_q;
    cap_en  = 1'b0;
    rdat_en = 1'b0;
    unique case (state_q)
      XF_IDLE: begin
        if (start_i) begin
          state_d = XF_BUSY;
          cyc_d   = 1'b1;
          cap_en  = 1'b1;
          rty_d   = '0;
        end else if (cs_idle_i) begin
          cyc_d = 1'b0;
        end
      end
      XF_BUSY: begin
        if (err_i) begin
          rdat_d  = '1;
          rdat_en = 1'b1;
          state_d = XF_DONE;
        end else if (ack_i) begin
          if (!we_q) begin
            rdat_d  = dat_i;
            rdat_en = 1'b1;
          end
          state_d = XF_DONE;
        end else if (rty_i) begin
          if (rty_q == RTY_LIMIT) begin
            rdat_d  = '1;
            rdat_en = 1'b1;
            state_d = XF_DONE;
          end else begin
            rty_d   = rty_q + 1'b1;
            state_d = XF_GAP;
          end
        end
      end
      XF_GAP: begin
        state_d = XF_BUSY;
      end
      XF_DONE: begin
        if (strobes_idle_i) state_d = XF_IDLE;
      end
      default: begin
        state_d = XF_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_IDLE;
      cyc_q   <= 1'b0;
      rty_q   <= '0;
      we_q    <= 1'b0;
      adr_q   <= '0;
      sel_q   <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      cyc_q   <= cyc_d;
      rty_q   <= rty_d;
      if (cap_en) begin
        we_q   <= start_we_i;
        adr_q  <= addr_i;
        sel_q  <= sel_i;
        wdat_q <= wdata_i;
      end
      if (rdat_en) begin
        rdat_q <= rdat_d;
      end
    end
  end

  assign cyc_o   = cyc_q;
  assign stb_o   = (state_q == XF_BUSY);
  assign we_o    = we_q;
  assign adr_o   = adr_q;
  assign sel_o   = sel_q;
  assign dat_o   = wdat_q;
  assign rdata_o = rdat_q;
  assign done_o  = (state_q == XF_DONE);

endmodule

// File: rtl/async_wb_bridge.sv
module async_wb_bridge #(
  parameter int DW        = 32,
  parameter int AW        = 16,
  parameter int RETRY_MAX = 3,
  localparam int NB       = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] cpu_addr_i,
  inout  wire  [DW-1:0] cpu_data_io,
  input  logic          cpu_cs_ni,
  input  logic          cpu_rd_ni,
  input  logic          cpu_wr_ni,
  input  logic [NB-1:0] cpu_be_ni,
  output logic          cpu_wait_no,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic          wb_we_o,
  output logic [AW-1:0] wb_adr_o,
  output logic [NB-1:0] wb_sel_o,
  output logic [DW-1:0] wb_dat_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack_i,
  input  logic          wb_rty_i,
  input  logic          wb_err_i
);

  localparam int SW = NB + 3;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  // synchronise processor controls
  logic [SW-1:0] ctl_raw;
  logic [SW-1:0] ctl_s;
  logic          cs_s_n;
  logic          rd_s_n;
  logic          wr_s_n;
  logic [NB-1:0] be_s_n;

  assign ctl_raw = {cpu_be_ni, cpu_cs_ni, cpu_rd_ni, cpu_wr_ni};

  abr_sync #(
    .W      (SW),
    .RST_VAL({SW{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_q),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  assign {be_s_n, cs_s_n, rd_s_n, wr_s_n} = ctl_s;

  // edge detection
  logic start;
  logic start_we;
  logic strobes_idle;
  logic cs_idle;

  abr_strobe_edge u_edge (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_q),
    .cs_s_ni       (cs_s_n),
    .rd_s_ni       (rd_s_n),
    .wr_s_ni       (wr_s_n),
    .start_o       (start),
    .start_we_o    (start_we),
    .strobes_idle_o(strobes_idle),
    .cs_idle_o     (cs_idle)
  );

  // transfer sequencer
  logic [DW-1:0] bus_in;
  logic [DW-1:0] rdata;
  logic          xfer_done;

  assign bus_in = cpu_data_io;

  abr_xfer_fsm #(
    .DW       (DW),
    .AW       (AW),
    .RETRY_MAX(RETRY_MAX)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_q),
    .start_i       (start),
    .start_we_i    (start_we),
    .strobes_idle_i(strobes_idle),
    .cs_idle_i     (cs_idle),
    .addr_i        (cpu_addr_i),
    .wdata_i       (bus_in),
    .sel_i         (~be_s_n),
    .ack_i         (wb_ack_i),
    .rty_i         (wb_rty_i),
    .err_i         (wb_err_i),
    .dat_i         (wb_dat_i),
    .cyc_o         (wb_cyc_o),
    .stb_o         (wb_stb_o),
    .we_o          (wb_we_o),
    .adr_o         (wb_adr_o),
    .sel_o         (wb_sel_o),
    .dat_o         (wb_dat_o),
    .rdata_o       (rdata),
    .done_o        (xfer_done)
  );

  // processor-facing outputs
  logic bus_oe;
  logic cpu_active;

  assign bus_oe      = ~cpu_cs_ni & ~cpu_rd_ni;
  assign cpu_active  = ~cpu_cs_ni & (~cpu_rd_ni | ~cpu_wr_ni);
  assign cpu_wait_no = ~(cpu_active & ~xfer_done);
  assign cpu_data_io = bus_oe ? rdata : {DW{1'bz}};

endmodule

// File: rtl/abr_checker.sv
module abr_checker #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wb_cyc_o,
  input logic          wb_stb_o,
  input logic          wb_we_o,
  input logic [AW-1:0] wb_adr_o,
  input logic          wb_ack_i,
  input logic          wb_err_i,
  input logic          cpu_wait_no
);

  AST_STB_INSIDE_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> wb_cyc_o); // R4

  AST_WAIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> !cpu_wait_no); // R10

  AST_ADR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_o && $past(wb_stb_o)) |-> ($stable(wb_adr_o) && $stable(wb_we_o))); // R2

  AST_STB_DROP_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_o && wb_ack_i) |=> !wb_stb_o); // R3

  AST_STB_DROP_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_o && wb_err_i) |=> !wb_stb_o); // R8

endmodule

bind async_wb_bridge abr_checker #(.AW(AW)) u_abr_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wb_cyc_o   (wb_cyc_o),
  .wb_stb_o   (wb_stb_o),
  .wb_we_o    (wb_we_o),
  .wb_adr_o   (wb_adr_o),
  .wb_ack_i   (wb_ack_i),
  .wb_err_i   (wb_err_i),
  .cpu_wait_no(cpu_wait_no)
);

// File: tb/tb_async_wb_bridge.sv
`timescale 1ns/1ps
module tb_async_wb_bridge;

  localparam int DW = 32;
  localparam int AW = 16;
  localparam int NB = 4;
  localparam int RMAX = 3;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          cs_n, rd_n, wr_n;
  logic [NB-1:0] be_n;
  logic          wait_n;
  logic          cyc, stb, we;
  logic [AW-1:0] adr;
  logic [NB-1:0] sel;
  logic [DW-1:0] dato, dati;
  logic          ack, rty, err;
  wire  [DW-1:0] data_bus;
  logic          drv_en;
  logic [DW-1:0] drv_val;

  assign data_bus = drv_en ? drv_val : {DW{1'bz}};

  async_wb_bridge #(.DW(DW), .AW(AW), .RETRY_MAX(RMAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_data_io(data_bus),
    .cpu_cs_ni(cs_n), .cpu_rd_ni(rd_n), .cpu_wr_ni(wr_n), .cpu_be_ni(be_n),
    .cpu_wait_no(wait_n), .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we),
    .wb_adr_o(adr), .wb_sel_o(sel), .wb_dat_o(dato), .wb_dat_i(dati),
    .wb_ack_i(ack), .wb_rty_i(rty), .wb_err_i(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // slave model configuration (written only by the stimulus process)
  int       lat;
  int       rty_budget;
  bit       err_mode;

  // slave model state
  logic [DW-1:0] mem [16];
  int            dly;
  int            rty_total;
  logic          last_we;
  logic [NB-1:0] last_sel;
  int            stb_rises;
  int            cyc_falls;
  logic          stb_prev, cyc_prev;

  function automatic logic [DW-1:0] init_word(input int i);
    return (32'h0101_0101 * i) ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [NB-1:0] ben);
    logic [DW-1:0] r;
    r = old;
    for (int b = 0; b < NB; b++) if (!ben[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  assign dati = mem[adr[3:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; rty <= 1'b0; err <= 1'b0; dly <= 0; rty_total <= 0;
      last_we <= 1'b0; last_sel <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
    end else begin
      ack <= 1'b0; rty <= 1'b0; err <= 1'b0;
      if (cyc && stb && !ack && !rty && !err) begin
        if (dly >= lat) begin
          dly <= 0;
          if (err_mode) err <= 1'b1;
          else if (rty_total < rty_budget) begin
            rty <= 1'b1;
            rty_total <= rty_total + 1;
          end else begin
            ack <= 1'b1;
            last_we <= we;
            last_sel <= sel;
            if (we)
              for (int b = 0; b < NB; b++)
                if (sel[b]) mem[adr[3:0]][8*b +: 8] <= dato[8*b +: 8];
          end
        end else dly <= dly + 1;
      end else dly <= 0;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_rises <= 0; cyc_falls <= 0; stb_prev <= 1'b0; cyc_prev <= 1'b0;
    end else begin
      stb_prev <= stb;
      cyc_prev <= cyc;
      if (stb && !stb_prev) stb_rises <= stb_rises + 1;
      if (!cyc && cyc_prev) cyc_falls <= cyc_falls + 1;
    end
  end

  logic [DW-1:0] ref_mem [16];

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cs_low();
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk); cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic cpu_xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic [NB-1:0] ben, output logic [DW-1:0] rdv);
    int n;
    @(negedge clk);
    addr = a; be_n = ben; drv_val = wd; drv_en = w;
    @(negedge clk);
    if (w) wr_n = 1'b0; else rd_n = 1'b0;
    #1;
    chk(wait_n == 1'b0, "R10 wait on strobe", {31'd0, wait_n}, 32'd0);
    n = 0;
    while (wait_n == 1'b0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    rdv = data_bus;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; drv_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] rv, wd;
    logic [NB-1:0] bn;
    logic [AW-1:0] a;
    int s0, c0;
    bit w;
    void'($urandom(32'h0BAD_5EED));
    for (int i = 0; i < 16; i++) ref_mem[i] = init_word(i);
    lat = 1; rty_budget = 0; err_mode = 1'b0;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; be_n = '1; addr = '0;
    drv_en = 1'b0; drv_val = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cyc == 1'b0 && stb == 1'b0, "R1 cyc/stb idle", {30'd0, cyc, stb}, 32'd0);
    chk(wait_n == 1'b1, "R1 wait released", {31'd0, wait_n}, 32'd1);

    // R2 / R3 directed
    cs_low();
    cpu_xfer(1'b1, 16'h0003, 32'hDEAD_BEEF, 4'b0000, rv);
    ref_mem[3] = 32'hDEAD_BEEF;
    chk(mem[3] == ref_mem[3], "R2 write data", mem[3], ref_mem[3]);
    chk(last_we == 1'b1 && last_sel == 4'hF, "R2 we/sel", {27'd0, last_we, last_sel}, {27'd0, 1'b1, 4'hF});
    cs_high();
    cs_low();
    cpu_xfer(1'b0, 16'h0003, '0, 4'b0000, rv);
    chk(rv == ref_mem[3], "R3 read data", rv, ref_mem[3]);
    chk(last_we == 1'b0, "R3 we low", {31'd0, last_we}, 32'd0);
    cs_high();
    chk(cyc == 1'b0, "R5 cyc closed", {31'd0, cyc}, 32'd0);

    // random singles
    for (int k = 0; k < 40; k++) begin
      w   = 1'($urandom_range(0, 1));
      a   = AW'($urandom_range(0, 15));
      wd  = $urandom;
      bn  = NB'($urandom_range(0, 15));
      lat = $urandom_range(0, 3);
      cs_low();
      cpu_xfer(w, a, wd, bn, rv);
      if (w) begin
        ref_mem[a[3:0]] = merge(ref_mem[a[3:0]], wd, bn);
        chk(mem[a[3:0]] == ref_mem[a[3:0]], "R2 random write", mem[a[3:0]], ref_mem[a[3:0]]);
        chk(last_sel == ~bn, "R2 sel from byte enables", {28'd0, last_sel}, {28'd0, ~bn});
      end else begin
        chk(rv == ref_mem[a[3:0]], "R3 random read", rv, ref_mem[a[3:0]]);
      end
      cs_high();
    end

    // R4 block of four under one chip select
    lat = 2;
    s0 = stb_rises; c0 = cyc_falls;
    cs_low();
    for (int k = 0; k < 4; k++) begin
      wd = $urandom;
      cpu_xfer(1'b1, AW'(8 + k), wd, 4'b0000, rv);
      ref_mem[8 + k] = wd;
    end
    chk(cyc_falls == c0, "R4 cyc held", 32'(cyc_falls - c0), 32'd0);
    chk(stb_rises == s0 + 4, "R4 one stb per strobe", 32'(stb_rises - s0), 32'd4);
    cs_high();
    chk(cyc == 1'b0, "R5 cyc closed after block", {31'd0, cyc}, 32'd0);
    chk(mem[11] == ref_mem[11], "R4 last block write", mem[11], ref_mem[11]);

    // R6 two retries then ack
    lat = 0;
    s0 = stb_rises;
    rty_budget = rty_total + 2;
    cs_low();
    cpu_xfer(1'b0, 16'h0005, '0, 4'b0000, rv);
    cs_high();
    chk(stb_rises == s0 + 3, "R6 reissue count", 32'(stb_rises - s0), 32'd3);
    chk(rv == ref_mem[5], "R6 data after retry", rv, ref_mem[5]);

    // R7 retry limit
    s0 = stb_rises;
    rty_budget = rty_total + 20;
    cs_low();
    cpu_xfer(1'b0, 16'h0006, '0, 4'b0000, rv);
    cs_high();
    rty_budget = rty_total;
    chk(stb_rises == s0 + RMAX + 1, "R7 attempts", 32'(stb_rises - s0), 32'(RMAX + 1));
    chk(rv == '1, "R7 all-ones data", rv, '1);

    // R8 error
    s0 = stb_rises;
    err_mode = 1'b1;
    cs_low();
    cpu_xfer(1'b0, 16'h0007, '0, 4'b0000, rv);
    cs_high();
    err_mode = 1'b0;
    chk(stb_rises == s0 + 1, "R8 single attempt", 32'(stb_rises - s0), 32'd1);
    chk(rv == '1, "R8 all-ones data", rv, '1);

    // R9 write after all-ones read: no bus contention from the bridge
    cs_low();
    cpu_xfer(1'b1, 16'h0002, 32'h0000_5A5A, 4'b0000, rv);
    cs_high();
    ref_mem[2] = 32'h0000_5A5A;
    chk(mem[2] == ref_mem[2], "R9 write data undisturbed", mem[2], ref_mem[2]);
    chk(rv == 32'h0000_5A5A, "R9 bus carries processor data", rv, 32'h0000_5A5A);

    // R11 strobe with chip select high
    s0 = stb_rises;
    @(negedge clk); addr = 16'h0001; rd_n = 1'b0;
    #1;
    chk(wait_n == 1'b1, "R11 no wait", {31'd0, wait_n}, 32'd1);
    repeat (8) @(negedge clk);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(stb_rises == s0 && cyc == 1'b0, "R11 no transfer", 32'(stb_rises - s0), 32'd0);

    // R12 read-modify-write
    c0 = cyc_falls;
    lat = 1;
    cs_low();
    cpu_xfer(1'b0, 16'h000C, '0, 4'b0000, rv);
    chk(rv == ref_mem[12], "R12 read phase", rv, ref_mem[12]);
    wd = rv ^ 32'h0000_00FF;
    cpu_xfer(1'b1, 16'h000C, wd, 4'b1110, rv);
    ref_mem[12] = merge(ref_mem[12], wd, 4'b1110);
    chk(cyc_falls == c0 && cyc == 1'b1, "R12 single cycle", 32'(cyc_falls - c0), 32'd0);
    cs_high();
    chk(mem[12] == ref_mem[12], "R12 modified value", mem[12], ref_mem[12]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule